// File: doc/BRIEF.md
# Power Management Window Decode and System Control Interrupt

This block is the register core of a power management function on a PCI bus. It holds two I/O base registers that can be moved by configuration writes. The first base places a 128-byte power management window and the second places a 16-byte SMBus window. Each window is decoded only while its own enable bit, held in a separate configuration byte, is set. Incoming I/O addresses are compared against both bases, and the block drives one hit line for each window.

The block also keeps a 16-bit event status register and a 16-bit event enable register. Hardware event pulses set status bits, and software clears them by writing ones. Four event bits can raise the level-sensitive system control interrupt: timer overflow, global lock, power button and RTC alarm. The interrupt is masked completely while the interrupt pin byte is zero. A timer-arm request tells the external free-running timer when an overflow interrupt has to be scheduled.

Configuration writes and event register writes are single-cycle commands that are always accepted, so there is no valid/ready handshake and no back-pressure. All control and status pins are plain levels.

Top module: `pm_sci_decode`

## Requirements
- R1: After reset, configuration bytes 0x48 and 0x90 read 0x01, bytes 0x49..0x4B and 0x91..0x93 read 0x00, bytes 0x41 and 0xD2 read 0x00, both hit outputs are low, status and enable are 0x0000, and the interrupt is low.
- R2: A write to byte 0x48 keeps only bit 7, and bit 0 always reads back as 1. Byte 0x49 keeps all 8 bits. Bytes 0x4A and 0x4B always read 0. The stored base is bits 15:7.
- R3: A write to byte 0x90 keeps only bits 7:4, and bit 0 always reads back as 1. Byte 0x91 keeps all 8 bits. Bytes 0x92 and 0x93 always read 0. The stored base is bits 15:4.
- R4: Byte 0xD2 keeps only its low 4 bits. Byte 0x41 keeps all 8 bits.
- R5: `pm_hit` is high exactly when bit 7 of byte 0x41 is set and io_addr[15:7] equals the power management base bits 15:7.
- R6: `smb_hit` is high exactly when bit 0 of byte 0xD2 is set and io_addr[15:4] equals the SMBus base bits 15:4.
- R7: Each `evt_set` bit sets the matching status bit. A status clear write clears every bit that is written as 1. If a set and a clear hit the same bit in the same cycle, the set wins. `evt_en_we` loads the enable register.
- R8: `sci` is high when (status AND enable) is nonzero on bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC alarm). Every other bit has no effect on `sci`.
- R9: Byte 0x3D (interrupt pin) resets to 0x01 and is writable. While it reads 0x00, `sci` stays low whatever the status and enable are.
- R10: `tmr_arm` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R11: A write to any other configuration byte is ignored, and any other byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_waddr | input | 8 | Configuration write byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | 8 | Configuration read byte offset |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled power management window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window |
| evt_set | input | 16 | Event pulses that set status bits |
| evt_clr_we | input | 1 | Status write-one-to-clear strobe |
| evt_clr_data | input | 16 | Status bits to clear |
| evt_en_we | input | 1 | Enable register write strobe |
| evt_en_data | input | 16 | Enable register write data |
| evt_sts | output | 16 | Event status register |
| evt_en | output | 16 | Event enable register |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Request to schedule the timer overflow interrupt |

## Verification
Read data and both hit lines are combinational from the stored registers and `io_addr`. A change in `io_addr` therefore shows within the same cycle, and a configuration write shows right after the clock edge that takes it. Status, enable, `sci` and `tmr_arm` take one register stage, so each result is due at the first edge after the command. The bench drives every command on a falling edge and holds it through one rising edge. It samples at the next falling edge, half a period after the register stage updates. It samples address sweeps one nanosecond after each new address, with no clock edge in between.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned CFG_DW = 8;

  // configuration byte offsets
  localparam logic [7:0] OFS_IRQ_PIN  = 8'h3D;
  localparam logic [7:0] OFS_PM_CTL   = 8'h41;
  localparam logic [7:0] OFS_PM_BASE  = 8'h48;
  localparam logic [7:0] OFS_SMB_BASE = 8'h90;
  localparam logic [7:0] OFS_SMB_CTL  = 8'hD2;

  // enable bit positions inside the control bytes
  localparam int unsigned PM_CTL_EN_BIT  = 7;
  localparam int unsigned SMB_CTL_EN_BIT = 0;
  localparam int unsigned SMB_CTL_KEEP   = 4;

  // event bit positions that can raise the interrupt
  localparam int unsigned EV_TIMER  = 0;
  localparam int unsigned EV_GLOCK  = 5;
  localparam int unsigned EV_PWRBTN = 8;
  localparam int unsigned EV_RTC    = 10;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_sci_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned PM_LOG2     = 7,
  parameter int unsigned SMB_LOG2    = 4,
  parameter logic [7:0]  IRQ_PIN_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic [CFG_AW-1:0] rd_addr,
  output logic [CFG_DW-1:0] rd_data,
  output logic [ADDR_W-1:0] pm_base,
  output logic              pm_en,
  output logic [ADDR_W-1:0] smb_base,
  output logic              smb_en,
  output logic              irq_pin_nz
);
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PM_HI  = ADDR_W - PM_LOG2;
  localparam int unsigned SMB_HI = ADDR_W - SMB_LOG2;

  logic [PM_HI-1:0]        pm_hi_q, pm_hi_d;
  logic [SMB_HI-1:0]       smb_hi_q, smb_hi_d;
  logic [7:0]              pm_ctl_q;
  logic [SMB_CTL_KEEP-1:0] smb_ctl_q;
  logic [7:0]              pin_q;

  logic [WORD_W-1:0] pm_word, smb_word, pm_wr_word, smb_wr_word;
  logic              hit_pm_base, hit_smb_base;

  // 32-bit views of the stored bases, bit 0 forced high
  always_comb begin
    pm_word  = '0;
    smb_word = '0;
    pm_word[ADDR_W-1:PM_LOG2]   = pm_hi_q;
    smb_word[ADDR_W-1:SMB_LOG2] = smb_hi_q;
    pm_word[0]  = 1'b1;
    smb_word[0] = 1'b1;
  end

  assign hit_pm_base  = (wr_addr[7:2] == OFS_PM_BASE[7:2]);
  assign hit_smb_base = (wr_addr[7:2] == OFS_SMB_BASE[7:2]);

  always_comb begin
    pm_wr_word  = pm_word;
    smb_wr_word = smb_word;
    pm_wr_word[8*wr_addr[1:0] +: 8]  = wr_data;
    smb_wr_word[8*wr_addr[1:0] +: 8] = wr_data;
    pm_hi_d  = pm_hi_q;
    smb_hi_d = smb_hi_q;
    if (wr_en && hit_pm_base)  pm_hi_d  = pm_wr_word[ADDR_W-1:PM_LOG2];
    if (wr_en && hit_smb_base) smb_hi_d = smb_wr_word[ADDR_W-1:SMB_LOG2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_hi_q   <= '0;
      smb_hi_q  <= '0;
      pm_ctl_q  <= '0;
      smb_ctl_q <= '0;
      pin_q     <= IRQ_PIN_RST;
    end else begin
      pm_hi_q  <= pm_hi_d;
      smb_hi_q <= smb_hi_d;
      if (wr_en && wr_addr == OFS_PM_CTL)  pm_ctl_q  <= wr_data;
      if (wr_en && wr_addr == OFS_SMB_CTL) smb_ctl_q <= wr_data[SMB_CTL_KEEP-1:0];
      if (wr_en && wr_addr == OFS_IRQ_PIN) pin_q     <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[7:2] == OFS_PM_BASE[7:2])       rd_data = pm_word[8*rd_addr[1:0] +: 8];
    else if (rd_addr[7:2] == OFS_SMB_BASE[7:2]) rd_data = smb_word[8*rd_addr[1:0] +: 8];
    else if (rd_addr == OFS_PM_CTL)             rd_data = pm_ctl_q;
    else if (rd_addr == OFS_SMB_CTL)            rd_data = {{(8-SMB_CTL_KEEP){1'b0}}, smb_ctl_q};
    else if (rd_addr == OFS_IRQ_PIN)            rd_data = pin_q;
  end

  assign pm_base    = pm_word[ADDR_W-1:0];
  assign smb_base   = smb_word[ADDR_W-1:0];
  assign pm_en      = pm_ctl_q[PM_CTL_EN_BIT];
  assign smb_en     = smb_ctl_q[SMB_CTL_EN_BIT];
  assign irq_pin_nz = (pin_q != '0);
endmodule

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_LOG2 = 7
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = en && (addr[ADDR_W-1:WIN_LOG2] == base[ADDR_W-1:WIN_LOG2]);
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci #(
  parameter int unsigned     EVT_W    = 16,
  parameter logic [EVT_W-1:0] SCI_MASK = 16'h0521,
  parameter int unsigned     TMR_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_set,
  input  logic             clr_we,
  input  logic [EVT_W-1:0] clr_data,
  input  logic             en_we,
  input  logic [EVT_W-1:0] en_data,
  input  logic             pin_nz,
  output logic [EVT_W-1:0] sts_o,
  output logic [EVT_W-1:0] en_o,
  output logic             sci_o,
  output logic             tmr_arm_o
);
  logic [EVT_W-1:0] sts_q, en_q, clr_mask;

  assign clr_mask = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_mask) | evt_set;
      if (en_we) en_q <= en_data;
    end
  end

  assign sts_o     = sts_q;
  assign en_o      = en_q;
  assign sci_o     = pin_nz && ((sts_q & en_q & SCI_MASK) != '0);
  assign tmr_arm_o = en_q[TMR_BIT] && !sts_q[TMR_BIT];

  // R7: a pulsed event is visible in status at the next edge
  p_set_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));

  // R7: a clear with no competing set leaves the written bits at zero
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt_set == '0) |=> ((sts_q & $past(clr_data)) == '0));
endmodule

// File: rtl/pm_sci_decode.sv
module pm_sci_decode
  import pm_sci_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned PM_LOG2     = 7,
  parameter int unsigned SMB_LOG2    = 4,
  parameter int unsigned EVT_W       = 16,
  parameter logic [7:0]  IRQ_PIN_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_waddr,
  input  logic [7:0]        cfg_wdata,
  input  logic [7:0]        cfg_raddr,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              pm_hit,
  output logic              smb_hit,
  input  logic [EVT_W-1:0]  evt_set,
  input  logic              evt_clr_we,
  input  logic [EVT_W-1:0]  evt_clr_data,
  input  logic              evt_en_we,
  input  logic [EVT_W-1:0]  evt_en_data,
  output logic [EVT_W-1:0]  evt_sts,
  output logic [EVT_W-1:0]  evt_en,
  output logic              sci,
  output logic              tmr_arm
);
  localparam logic [EVT_W-1:0] SCI_MASK =
    (EVT_W'(1) << EV_TIMER) | (EVT_W'(1) << EV_GLOCK) |
    (EVT_W'(1) << EV_PWRBTN) | (EVT_W'(1) << EV_RTC);

  logic [ADDR_W-1:0] pm_base, smb_base;
  logic              pm_en, smb_en, pin_nz;

  pm_cfg_regs #(
    .ADDR_W(ADDR_W), .PM_LOG2(PM_LOG2), .SMB_LOG2(SMB_LOG2), .IRQ_PIN_RST(IRQ_PIN_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
    .pm_base(pm_base), .pm_en(pm_en),
    .smb_base(smb_base), .smb_en(smb_en),
    .irq_pin_nz(pin_nz)
  );

  pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(PM_LOG2)) u_pm_dec (
    .en(pm_en), .base(pm_base), .addr(io_addr), .hit(pm_hit)
  );

  pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(SMB_LOG2)) u_smb_dec (
    .en(smb_en), .base(smb_base), .addr(io_addr), .hit(smb_hit)
  );

  pm_event_sci #(.EVT_W(EVT_W), .SCI_MASK(SCI_MASK), .TMR_BIT(EV_TIMER)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .evt_set(evt_set),
    .clr_we(evt_clr_we), .clr_data(evt_clr_data),
    .en_we(evt_en_we), .en_data(evt_en_data),
    .pin_nz(pin_nz),
    .sts_o(evt_sts), .en_o(evt_en),
    .sci_o(sci), .tmr_arm_o(tmr_arm)
  );

  // R5: decoder hit never occurs while the control byte disables the window
  p_pm_hit_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> pm_en);

  // R6: same for the SMBus window
  p_smb_hit_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> smb_en);

  // R9: interrupt stays low while the pin byte is zero
  p_sci_pin_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_nz |-> !sci);

  // R10: a pending timer status never coexists with an arm request
  p_tmr_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_arm |-> (evt_en[EV_TIMER] && !evt_sts[EV_TIMER]));
endmodule

// File: tb/test_pm_sci_decode.sv
`timescale 1ns/1ps
module test_pm_sci_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_waddr = '0, cfg_wdata = '0, cfg_raddr = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;
  logic [15:0] evt_set = '0, evt_clr_data = '0, evt_en_data = '0;
  logic        evt_clr_we = 1'b0, evt_en_we = 1'b0;
  logic [15:0] evt_sts, evt_en;
  logic        sci, tmr_arm;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [15:0] SCI_BITS = 16'h0521;

  always #2.5 clk = ~clk;

  pm_sci_decode i_pm_sci_decode (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit),
    .evt_set(evt_set), .evt_clr_we(evt_clr_we), .evt_clr_data(evt_clr_data),
    .evt_en_we(evt_en_we), .evt_en_data(evt_en_data),
    .evt_sts(evt_sts), .evt_en(evt_en), .sci(sci), .tmr_arm(tmr_arm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] cfg_rd(input logic [7:0] a);
    cfg_raddr = a;
    return cfg_rdata;
  endfunction

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_raddr = a;
    #0.5;
    check(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic evt_cmd(input logic [15:0] set, input logic clr, input logic [15:0] cd,
                         input logic enw, input logic [15:0] ed);
    @(negedge clk);
    evt_set = set; evt_clr_we = clr; evt_clr_data = cd; evt_en_we = enw; evt_en_data = ed;
    @(negedge clk);
    evt_set = '0; evt_clr_we = 1'b0; evt_en_we = 1'b0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_sts;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_check("R1 pm base b0", 8'h48, 8'h01);
    rd_check("R1 pm base b1", 8'h49, 8'h00);
    rd_check("R1 pm base b3", 8'h4B, 8'h00);
    rd_check("R1 smb base b0", 8'h90, 8'h01);
    rd_check("R1 smb base b2", 8'h92, 8'h00);
    rd_check("R1 pm ctl", 8'h41, 8'h00);
    rd_check("R1 smb ctl", 8'hD2, 8'h00);
    rd_check("R9 pin reset", 8'h3D, 8'h01);
    check("R1 hits", {30'h0, pm_hit, smb_hit}, 32'h0);
    check("R1 status", {16'h0, evt_sts}, 32'h0);
    check("R1 enable", {16'h0, evt_en}, 32'h0);
    check("R1 sci", {31'h0, sci}, 32'h0);

    // R2, R3, R4 byte masking sweeps
    for (int d = 0; d < 256; d++) begin
      cfg_wr(8'h48, 8'(d)); rd_check("R2 pm b0", 8'h48, 8'((d & 8'h80) | 1));
      cfg_wr(8'h49, 8'(d)); rd_check("R2 pm b1", 8'h49, 8'(d));
      cfg_wr(8'h4A, 8'(d)); rd_check("R2 pm b2", 8'h4A, 8'h00);
      cfg_wr(8'h90, 8'(d)); rd_check("R3 smb b0", 8'h90, 8'((d & 8'hF0) | 1));
      cfg_wr(8'h91, 8'(d)); rd_check("R3 smb b1", 8'h91, 8'(d));
      cfg_wr(8'h93, 8'(d)); rd_check("R3 smb b3", 8'h93, 8'h00);
      cfg_wr(8'hD2, 8'(d)); rd_check("R4 smb ctl", 8'hD2, 8'(d & 8'h0F));
      cfg_wr(8'h41, 8'(d)); rd_check("R4 pm ctl", 8'h41, 8'(d));
    end

    // R11 unrelated bytes ignored
    cfg_wr(8'h41, 8'h00); cfg_wr(8'hD2, 8'h00);
    cfg_wr(8'h48, 8'h80); cfg_wr(8'h49, 8'h12);
    cfg_wr(8'h90, 8'h50); cfg_wr(8'h91, 8'hA3);
    for (int a = 0; a < 256; a++) begin
      if (a != 'h3D && a != 'h41 && a != 'hD2 && (a & 'hFC) != 'h48 && (a & 'hFC) != 'h90) begin
        cfg_wr(8'(a), 8'hFF);
        rd_check("R11 other read", 8'(a), 8'h00);
      end
    end
    rd_check("R11 pm base kept", 8'h49, 8'h12);
    rd_check("R11 smb base kept", 8'h91, 8'hA3);
    rd_check("R11 pm ctl kept", 8'h41, 8'h00);

    // R5, R6 decode sweeps, windows disabled then enabled
    for (int a = 0; a < 65536; a += 7) begin
      io_addr = 16'(a); #1;
      check("R5 pm off", {31'h0, pm_hit}, 32'h0);
      check("R6 smb off", {31'h0, smb_hit}, 32'h0);
    end
    cfg_wr(8'h41, 8'h80); cfg_wr(8'hD2, 8'h01);
    for (int a = 0; a < 65536; a++) begin
      io_addr = 16'(a); #1;
      check("R5 pm on", {31'h0, pm_hit}, {31'h0, ((a & 'hFF80) == 'h1280)});
      check("R6 smb on", {31'h0, smb_hit}, {31'h0, ((a & 'hFFF0) == 'hA350)});
    end
    cfg_wr(8'h41, 8'h7F); cfg_wr(8'hD2, 8'h0E);
    io_addr = 16'h12C5; #1;
    check("R5 enable bit only", {31'h0, pm_hit}, 32'h0);
    io_addr = 16'hA35F; #1;
    check("R6 enable bit only", {31'h0, smb_hit}, 32'h0);

    // R7 set, clear, set-wins
    evt_cmd(16'hFFFF, 1'b0, '0, 1'b0, '0);
    check("R7 set all", {16'h0, evt_sts}, 32'hFFFF);
    evt_cmd('0, 1'b1, 16'h00F0, 1'b0, '0);
    check("R7 w1c", {16'h0, evt_sts}, 32'hFF0F);
    evt_cmd(16'h0003, 1'b1, 16'h000F, 1'b0, '0);
    check("R7 set wins", {16'h0, evt_sts}, 32'hFF03);
    evt_cmd('0, 1'b0, '0, 1'b1, 16'h5A5A);
    check("R7 enable load", {16'h0, evt_en}, 32'h5A5A);

    // R8 single-bit enable sweep with all status set
    evt_cmd(16'hFFFF, 1'b0, '0, 1'b0, '0);
    for (int b = 0; b < 16; b++) begin
      evt_cmd('0, 1'b0, '0, 1'b1, 16'(1 << b));
      check("R8 enable bit", {31'h0, sci}, {31'h0, SCI_BITS[b]});
    end
    // R8 single-bit status sweep with all enabled
    evt_cmd('0, 1'b0, '0, 1'b1, 16'hFFFF);
    for (int b = 0; b < 16; b++) begin
      evt_cmd('0, 1'b1, 16'hFFFF, 1'b0, '0);
      evt_cmd(16'(1 << b), 1'b0, '0, 1'b0, '0);
      check("R8 status bit", {31'h0, sci}, {31'h0, SCI_BITS[b]});
    end

    // R9 pin gate
    evt_cmd(16'h0400, 1'b0, '0, 1'b0, '0);
    check("R9 sci pin set", {31'h0, sci}, 32'h1);
    cfg_wr(8'h3D, 8'h00);
    check("R9 sci pin zero", {31'h0, sci}, 32'h0);
    cfg_wr(8'h3D, 8'h02);
    check("R9 sci pin restored", {31'h0, sci}, 32'h1);

    // R10 timer arm over the four combinations
    for (int c = 0; c < 4; c++) begin
      evt_cmd('0, 1'b1, 16'hFFFF, 1'b1, {15'h0, c[0]});
      if (c[1]) evt_cmd(16'h0001, 1'b0, '0, 1'b0, '0);
      exp_sts = {15'h0, c[1]};
      check("R10 tmr arm", {31'h0, tmr_arm}, {31'h0, (c[0] == 1'b1) && (exp_sts[0] == 1'b0)});
    end

    // R1 reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_check("R1 re-reset pm b1", 8'h49, 8'h00);
    rd_check("R1 re-reset smb b0", 8'h90, 8'h01);
    check("R1 re-reset status", {16'h0, evt_sts}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule